// File: doc/BRIEF.md
# Dual-Compare Interval Timer

A single up-counting timer channel with a small register file: a control word, a live count, and two terminal compare values, A and B. The count advances on count events. A count event is one of three things: a built-in tick every fourth system clock, a pulse from a neighbouring timer, or a rising edge on an external input pin. The same pin can instead gate the internal events, or restart the count. When the count equals the active compare value on a count event, the count returns to zero. That event sets a sticky terminal flag and can raise a one-cycle interrupt request.

In alternate mode the channel runs up to A, then up to B, and back to A again. A status bit shows which of the two is active. In one-shot mode the channel clears its own run bit after one pass. With alternate mode on, one pass covers both the A and B segments. The run bit is write-protected: a write changes it only when a key bit is set in the same write.

Top module: `interval_timer`

## Requirements
- R1: After reset, the control word (address 0) reads 0x0000 and `irq` is low. The address map is: 0 control, 1 count, 2 compare A, 3 compare B. The control bits are: 0 run, 1 key, 2 irq-enable, 3 continuous, 4 alternate, 5 external-clock, 6 prescale, 7 retrigger, 8 terminal flag, 9 B-active status (read-only).
- R2: A control write changes the run bit only when bit 1 (key) of the written data is 1. The key bit always reads 0.
- R3: With external-clock and prescale both 0 and the gate open, the count advances by exactly one every four system clocks.
- R4: With prescale 1 and external-clock 0, the count advances once per clock cycle in which `presc_in` is high.
- R5: With retrigger 0 and external-clock 0, a low level on `tmr_pin` freezes the count and a high level lets it advance.
- R6: With retrigger 1 and external-clock 0, a rising edge on `tmr_pin` resets the count to 0 three clock edges after the pin rises. The pin level does not gate counting.
- R7: With external-clock 1, each rising edge of `tmr_pin` adds one to the count three clock edges later. `presc_in` and the retrigger bit have no effect.
- R8: A count event while the count equals the active compare value returns the count to 0 and sets the terminal flag, whatever the irq-enable bit is. A control write with bit 8 = 0 clears the flag.
- R9: When irq-enable is 1, `irq` is high for exactly the one cycle that follows the clock edge of each terminal event.
- R10: With alternate 1, the active compare switches between A and B on every terminal event. The status bit reads 1 while B is active.
- R11: With alternate 0, only compare A is used, compare B has no effect, and the status bit stays 0.
- R12: With continuous 0, the run bit clears itself at the terminal event that ends the pass: after A when alternate is 0, and after B when alternate is 1. Further count events then leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| presc_in | input | 1 | Count pulse from a neighbouring timer |
| tmr_pin | input | 1 | External timer input (asynchronous) |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A register write or a `presc_in` pulse takes effect at the clock edge that samples it. That same edge updates the count, the flag, the status bit and `irq`. The bench therefore drives on a falling edge and reads back on the next falling edge, and it checks that `irq` has dropped one cycle after that. A change on `tmr_pin` passes through the synchronizer and edge detector, so it acts on the third rising edge after the change. The retrigger test confirms that the count is still unchanged after two edges and at zero after three. Because the phase of the internal divide-by-four is not visible at the ports, that case is checked as an exact increase of two over any eight-cycle window.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMPA  = 2'd2,
    REG_CMPB  = 2'd3
  } reg_sel_e;

  // control word bit positions
  localparam int B_RUN  = 0;
  localparam int B_KEY  = 1;
  localparam int B_IE   = 2;
  localparam int B_CONT = 3;
  localparam int B_ALT  = 4;
  localparam int B_EXT  = 5;
  localparam int B_PRE  = 6;
  localparam int B_RTG  = 7;
  localparam int B_FLAG = 8;
  localparam int B_SEG  = 9;
  localparam int CTRL_USED = 10;

  typedef struct packed {
    logic rtg;
    logic pre;
    logic ext;
    logic alt;
    logic cont;
    logic ie;
  } mode_t;

endpackage

// File: rtl/timer_event_src.sv
module timer_event_src #(
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic presc_in,
  input  logic ext,
  input  logic pre,
  input  logic rtg,
  output logic cnt_evt,
  output logic restart,
  output logic gate_lvl
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [SYNC:0] sh_q, sh_d;
  logic [DW-1:0] div_q, div_d;
  logic          tick, level, prev, rise, base;

  // synchronizer plus one history stage for edge detection
  always_comb sh_d = {sh_q[SYNC-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[SYNC-1];
  assign prev  = sh_q[SYNC];
  assign rise  = level & ~prev;

  // free-running internal divider
  assign tick = (div_q == DW'(DIV - 1));

  always_comb div_d = tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    base = pre ? presc_in : tick;
    if (ext)      cnt_evt = rise;
    else if (rtg) cnt_evt = base;
    else          cnt_evt = base & level;
  end

  assign restart  = ~ext & rtg & rise;
  assign gate_lvl = level;

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         alt,
  input  logic         cont,
  input  logic         cnt_evt,
  input  logic         restart,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         count_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_q,
  output logic         seg_b_q,
  output logic         term_evt,
  output logic         stop_req
);
  logic [W-1:0] active, count_d;
  logic         adv, hit, count_en, seg_d, do_restart;

  assign active     = (alt & seg_b_q) ? cmp_b : cmp_a;
  assign adv        = run & cnt_evt;
  assign hit        = (count_q == active);
  assign do_restart = run & restart;
  assign term_evt   = adv & hit & ~do_restart & ~count_wr;
  assign stop_req   = term_evt & ~cont & (~alt | seg_b_q);
  assign count_en   = count_wr | do_restart | adv;

  always_comb begin
    if (count_wr)        count_d = wr_data;
    else if (do_restart) count_d = '0;
    else if (hit)        count_d = '0;
    else                 count_d = count_q + 1'b1;
  end

  always_comb begin
    if (!alt)          seg_d = 1'b0;
    else if (term_evt) seg_d = ~seg_b_q;
    else               seg_d = seg_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_b_q <= 1'b0;
    else        seg_b_q <= seg_d;
  end

endmodule

// File: rtl/timer_ctrl_regs.sv
module timer_ctrl_regs
  import itmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wr_data,
  input  logic         term_evt,
  input  logic         stop_req,
  output logic         run_q,
  output mode_t        mode_q,
  output logic         flag_q,
  output logic         irq_q
);
  logic  run_d, flag_d, irq_d;
  mode_t mode_d;

  always_comb begin
    if (wr_ctrl && wr_data[B_KEY]) run_d = wr_data[B_RUN];
    else if (stop_req)             run_d = 1'b0;
    else                           run_d = run_q;
  end

  always_comb begin
    mode_d = mode_q;
    if (wr_ctrl) begin
      mode_d.rtg  = wr_data[B_RTG];
      mode_d.pre  = wr_data[B_PRE];
      mode_d.ext  = wr_data[B_EXT];
      mode_d.alt  = wr_data[B_ALT];
      mode_d.cont = wr_data[B_CONT];
      mode_d.ie   = wr_data[B_IE];
    end
  end

  always_comb begin
    if (term_evt)                         flag_d = 1'b1;
    else if (wr_ctrl && !wr_data[B_FLAG]) flag_d = 1'b0;
    else                                  flag_d = flag_q;
  end

  assign irq_d = term_evt & mode_q.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int W    = 16,
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         presc_in,
  input  logic         tmr_pin,
  output logic         irq
);
  logic [1:0]   rst_sh_q;
  logic         rst_sync_n;
  logic         wr_ctrl, count_wr, wr_cmpa, wr_cmpb, wr_key;
  logic [W-1:0] cmp_a_q, cmp_b_q, count_q;
  logic         run_q, flag_q, seg_b_q, term_evt, stop_req;
  logic         cnt_evt, restart, gate_lvl;
  logic         m_ext, m_rtg, m_alt, m_cont;
  mode_t        mode_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
  assign count_wr = wr_en && (wr_addr == REG_COUNT);
  assign wr_cmpa  = wr_en && (wr_addr == REG_CMPA);
  assign wr_cmpb  = wr_en && (wr_addr == REG_CMPB);
  assign wr_key   = wr_data[B_KEY];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cmp_a_q <= '0;
    else if (wr_cmpa) cmp_a_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cmp_b_q <= '0;
    else if (wr_cmpb) cmp_b_q <= wr_data;
  end

  assign m_ext  = mode_q.ext;
  assign m_rtg  = mode_q.rtg;
  assign m_alt  = mode_q.alt;
  assign m_cont = mode_q.cont;

  timer_event_src #(.DIV(DIV), .SYNC(SYNC)) u_src (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin      (tmr_pin),
    .presc_in (presc_in),
    .ext      (m_ext),
    .pre      (mode_q.pre),
    .rtg      (m_rtg),
    .cnt_evt  (cnt_evt),
    .restart  (restart),
    .gate_lvl (gate_lvl)
  );

  timer_count_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_q),
    .alt      (m_alt),
    .cont     (m_cont),
    .cnt_evt  (cnt_evt),
    .restart  (restart),
    .cmp_a    (cmp_a_q),
    .cmp_b    (cmp_b_q),
    .count_wr (count_wr),
    .wr_data  (wr_data),
    .count_q  (count_q),
    .seg_b_q  (seg_b_q),
    .term_evt (term_evt),
    .stop_req (stop_req)
  );

  timer_ctrl_regs #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_ctrl  (wr_ctrl),
    .wr_data  (wr_data),
    .term_evt (term_evt),
    .stop_req (stop_req),
    .run_q    (run_q),
    .mode_q   (mode_q),
    .flag_q   (flag_q),
    .irq_q    (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_data[B_RUN]  = run_q;
        rd_data[B_IE]   = mode_q.ie;
        rd_data[B_CONT] = mode_q.cont;
        rd_data[B_ALT]  = mode_q.alt;
        rd_data[B_EXT]  = mode_q.ext;
        rd_data[B_PRE]  = mode_q.pre;
        rd_data[B_RTG]  = mode_q.rtg;
        rd_data[B_FLAG] = flag_q;
        rd_data[B_SEG]  = seg_b_q;
      end
      REG_COUNT: rd_data = count_q;
      REG_CMPA:  rd_data = cmp_a_q;
      default:   rd_data = cmp_b_q;
    endcase
  end

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_ctrl,
  input logic         wr_key,
  input logic         count_wr,
  input logic         irq,
  input logic         run_q,
  input logic         flag_q,
  input logic         seg_b_q,
  input logic         term_evt,
  input logic         ext,
  input logic         rtg,
  input logic         alt,
  input logic         cont,
  input logic         gate_lvl,
  input logic [W-1:0] count_q
);

  assert_run_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_key && !term_evt) |=> (run_q == $past(run_q)));

  assert_gate_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && !rtg && !gate_lvl && !count_wr) |=> $stable(count_q));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> (count_q == '0));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> flag_q);

  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  assert_seg_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && alt) |=> (seg_b_q != $past(seg_b_q)));

  assert_seg_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !alt |=> !seg_b_q);

  assert_oneshot_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && !cont && (!alt || seg_b_q) && !wr_ctrl) |=> !run_q);

endmodule

bind interval_timer interval_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_ctrl  (wr_ctrl),
  .wr_key   (wr_key),
  .count_wr (count_wr),
  .irq      (irq),
  .run_q    (run_q),
  .flag_q   (flag_q),
  .seg_b_q  (seg_b_q),
  .term_evt (term_evt),
  .ext      (m_ext),
  .rtg      (m_rtg),
  .alt      (m_alt),
  .cont     (m_cont),
  .gate_lvl (gate_lvl),
  .count_q  (count_q)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  localparam int RUN = 0, KEY = 1, IE = 2, CONT = 3, ALT = 4, EXT = 5,
                 PRE = 6, RTG = 7, FLG = 8, SEG = 9;

  logic        clk, rst_n, wr_en, presc_in, tmr_pin;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        irq;
  int          n_chk, n_fail;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .presc_in(presc_in), .tmr_pin(tmr_pin), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic pulse();
    @(negedge clk);
    presc_in = 1'b1;
    @(negedge clk);
    presc_in = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    tmr_pin = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] cw(input int bits);
    return 16'(bits);
  endfunction

  // stop, clear count, load compares, then start with the given mode bits
  task automatic setup(input logic [15:0] a, input logic [15:0] b, input logic [15:0] mode);
    wr(2'd0, cw(1 << KEY));
    wr(2'd1, 16'd0);
    wr(2'd2, a);
    wr(2'd3, b);
    wr(2'd0, mode | cw((1 << KEY) | (1 << RUN)));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v);
    check("R1 ctrl reset", v, 0);
    check("R1 irq reset", irq, 0);
  endtask

  task automatic t_key();
    logic [15:0] v;
    wr(2'd0, cw(1 << RUN));
    rd(2'd0, v);
    check("R2 run without key", v[RUN], 0);
    wr(2'd0, cw((1 << RUN) | (1 << KEY)));
    rd(2'd0, v);
    check("R2 run with key", v[RUN], 1);
    check("R2 key reads 0", v[KEY], 0);
    wr(2'd0, cw(0));
    rd(2'd0, v);
    check("R2 run kept", v[RUN], 1);
  endtask

  task automatic t_internal();
    logic [15:0] c0, c1;
    setup(16'hFFFF, 16'h0, cw(1 << CONT));
    repeat (3) @(negedge clk);
    rd(2'd1, c0);
    repeat (8) @(negedge clk);
    rd(2'd1, c1);
    check("R3 internal tick rate", int'(c1 - c0), 2);
  endtask

  task automatic t_single();
    logic [15:0] v;
    setup(16'd3, 16'd0, cw((1 << CONT) | (1 << IE) | (1 << PRE)));
    pulse(); pulse(); pulse();
    rd(2'd1, v);
    check("R4 prescale count", v, 3);
    check("R9 no irq before wrap", irq, 0);
    pulse();
    rd(2'd1, v);
    check("R8 wrap to zero", v, 0);
    check("R9 irq on wrap", irq, 1);
    rd(2'd0, v);
    check("R8 flag set", v[FLG], 1);
    @(negedge clk);
    check("R9 irq one cycle", irq, 0);
    wr(2'd0, cw((1 << CONT) | (1 << IE) | (1 << PRE)));
    rd(2'd0, v);
    check("R8 flag cleared", v[FLG], 0);
    check("R8 still running", v[RUN], 1);
  endtask

  task automatic t_alt_oneshot();
    logic [15:0] v;
    setup(16'd1, 16'd2, cw((1 << ALT) | (1 << IE) | (1 << PRE)));
    pulse(); pulse();
    rd(2'd1, v);
    check("R10 end of A", v, 0);
    check("R9 irq at A", irq, 1);
    rd(2'd0, v);
    check("R10 B active", v[SEG], 1);
    check("R12 runs on after A", v[RUN], 1);
    pulse(); pulse();
    rd(2'd1, v);
    check("R10 counts to B", v, 2);
    pulse();
    rd(2'd1, v);
    check("R10 end of B", v, 0);
    rd(2'd0, v);
    check("R12 stop after B", v[RUN], 0);
    check("R10 back to A", v[SEG], 0);
    pulse();
    rd(2'd1, v);
    check("R12 stopped count", v, 0);
  endtask

  task automatic t_single_oneshot();
    logic [15:0] v;
    setup(16'd1, 16'd5, cw(1 << PRE));
    pulse(); pulse();
    rd(2'd0, v);
    check("R12 stop after A", v[RUN], 0);
    check("R9 no irq when disabled", irq, 0);
    check("R8 flag without irq enable", v[FLG], 1);
  endtask

  task automatic t_no_alt();
    logic [15:0] v;
    setup(16'd2, 16'd0, cw((1 << CONT) | (1 << PRE)));
    pulse(); pulse();
    rd(2'd1, v);
    check("R11 B ignored", v, 2);
    pulse(); pulse();
    rd(2'd1, v);
    check("R11 wraps on A", v, 1);
    rd(2'd0, v);
    check("R11 status stays 0", v[SEG], 0);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    set_pin(1'b0);
    setup(16'd100, 16'd0, cw((1 << CONT) | (1 << PRE)));
    pulse(); pulse();
    rd(2'd1, v);
    check("R5 gate low freezes", v, 0);
    set_pin(1'b1);
    pulse();
    rd(2'd1, v);
    check("R5 gate high counts", v, 1);
  endtask

  task automatic t_retrig();
    logic [15:0] v;
    set_pin(1'b0);
    setup(16'd100, 16'd0, cw((1 << CONT) | (1 << PRE) | (1 << RTG)));
    pulse(); pulse();
    rd(2'd1, v);
    check("R6 no gating", v, 2);
    @(negedge clk);
    tmr_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd1, v);
    check("R6 not yet restarted", v, 2);
    @(negedge clk);
    rd(2'd1, v);
    check("R6 restart to zero", v, 0);
    pulse();
    rd(2'd1, v);
    check("R6 counts after restart", v, 1);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    set_pin(1'b0);
    setup(16'd100, 16'd0, cw((1 << CONT) | (1 << PRE) | (1 << RTG) | (1 << EXT)));
    pulse(); pulse();
    rd(2'd1, v);
    check("R7 presc ignored", v, 0);
    @(negedge clk);
    tmr_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd1, v);
    check("R7 edge counts", v, 1);
    set_pin(1'b0);
    rd(2'd1, v);
    check("R7 no retrigger", v, 1);
    set_pin(1'b1);
    rd(2'd1, v);
    check("R7 second edge", v, 2);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; presc_in = 1'b0; tmr_pin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_key();
    t_internal();
    t_single();
    t_alt_oneshot();
    t_single_oneshot();
    t_no_alt();
    t_gate();
    t_retrig();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule